// File: doc/BRIEF.md
# Scaled-Index Shift-and-Add Unit

This unit forms scaled-index addresses in a single registered step. It shifts operand B left by a small immediate plus one and adds operand A. Because of that bias of one, a zero immediate still doubles B.

A two-bit mode input chooses what B means. B can be used at full width. Its lower half can also be taken as a signed or an unsigned index, and is then widened to the full width before the shift.

The sum appears one cycle after an accepted request. The output valid follows the input valid by one cycle. A three-bit condition field, which classifies the sum as negative, positive or zero, is refreshed only when the request asks for it. Carry out and overflow are not produced.

Top module: `shadd_agu`

## Requirements
- R1: The left shift applied to B is `sh + 1`, computed without wrap. With the default 2-bit `sh`, the shift therefore spans 1 to 4, and `sh = 0` shifts by one.
- R2: Bits of B shifted beyond XLEN are discarded, and the vacated low positions are filled with zeros.
- R3: `sum_o` equals the shifted B plus `opa`, modulo 2^XLEN. The carry out of the adder is dropped.
- R4: `mode` encoding: 2'b00 uses B at full width, 2'b01 selects signed word, 2'b10 selects unsigned word, and 2'b11 behaves exactly as 2'b00.
- R5: In signed word mode, the upper half of B is replaced before the shift by copies of bit XLEN/2-1 of B.
- R6: In unsigned word mode, the upper half of B is replaced by zeros before the shift.
- R7: A request with `in_valid` high at a rising edge appears on `sum_o` at that edge. `out_valid` is `in_valid` delayed by one cycle.
- R8: While `in_valid` is low, `sum_o` holds its previous value.
- R9: `cond_o` changes only on an edge where both `in_valid` and `rc_en` are high. It then takes the value of the new sum: bit 2 is set when the sum is negative as a signed number, bit 1 when it is positive, and bit 0 when it is zero.
- R10: While `rst_n` is low at a rising edge, `out_valid`, `sum_o` and `cond_o` all clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request accepted at this edge |
| mode | input | 2 | Operand-B interpretation (see R4) |
| sh | input | SH_W | Shift immediate; the shift is sh+1 |
| rc_en | input | 1 | Refresh the condition field with this result |
| opa | input | XLEN | Addend A |
| opb | input | XLEN | Index operand B |
| out_valid | output | 1 | Result on sum_o belongs to the last request |
| sum_o | output | XLEN | Registered shifted-and-added result |
| cond_o | output | 3 | {negative, positive, zero} of the last flagged sum |

## Verification
Random operands are mixed with directed ones.

- Directed B values with ones in the top bit, in the bit just below the half boundary, and in the lowest bit show whether the shift is biased, whether overflowing bits are dropped, and whether the two word modes extend the right bit.
- All four mode codes are tried against the same B so that the reserved code and full mode can be told apart from the word modes.
- Sums chosen to land exactly on zero, on a negative value and on a positive value separate the three condition bits.
- Cycles with `in_valid` or `rc_en` low show that the outputs hold.

// File: rtl/sadd_pkg.sv
// Package: shared types for the shift-and-add unit.
// Assumes a two-bit mode field; code 2'b11 is treated as full width.
package sadd_pkg;
    typedef enum logic [1:0] {
        MODE_FULL  = 2'b00,
        MODE_SWORD = 2'b01,
        MODE_UWORD = 2'b10,
        MODE_RSVD  = 2'b11
    } bmode_e;

    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
    } cond_t;
endpackage

// File: rtl/sadd_bext.sv
// Operand-B conditioner: passes B through, or rebuilds its upper half from
// its lower half (sign or zero). Assumes XLEN is even. Purely combinational.
module sadd_bext
    import sadd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [1:0]      mode,
    input  logic [XLEN-1:0] b_in,
    output logic [XLEN-1:0] b_out
);
    localparam int HALF = XLEN / 2;

    logic [HALF-1:0] low_half;
    assign low_half = b_in[HALF-1:0];

    // Select the upper half according to the mode.
    always_comb begin
        case (bmode_e'(mode))
            MODE_SWORD: b_out = {{HALF{low_half[HALF-1]}}, low_half};
            MODE_UWORD: b_out = {{HALF{1'b0}}, low_half};
            default:    b_out = b_in;
        endcase
    end
endmodule

// File: rtl/sadd_shl.sv
// Biased left shifter: shifts by sh+1 with zero fill, truncated to XLEN.
// One candidate per shift amount, selected by sh. Combinational.
module sadd_shl #(
    parameter int XLEN = 64,
    parameter int SH_W = 2
) (
    input  logic [SH_W-1:0] sh,
    input  logic [XLEN-1:0] val,
    output logic [XLEN-1:0] shifted
);
    localparam int NAMT = 1 << SH_W;

    logic [XLEN-1:0] cand [NAMT];

    for (genvar k = 0; k < NAMT; k++) begin : g_amt
        // Candidate for immediate k: shift by k+1.
        assign cand[k] = val << (k + 1);
    end

    assign shifted = cand[sh];
endmodule

// File: rtl/sadd_cond.sv
// Condition classifier: marks a value as signed-negative, positive or zero.
// Exactly one bit of the result is set. Combinational.
module sadd_cond
    import sadd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] val,
    output cond_t           cond
);
    // Derive the three mutually exclusive flags.
    always_comb begin
        cond.zero = (val == '0);
        cond.neg  = val[XLEN-1];
        cond.pos  = !val[XLEN-1] && (val != '0);
    end
endmodule

// File: rtl/shadd_agu.sv
// Top: shift-and-add unit for scaled-index addresses. sum = (B' << (sh+1)) + A,
// where B' is B or its extended lower half. One register stage.
// Assumes a synchronous active-low reset and an always-ready consumer.
module shadd_agu
    import sadd_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int SH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      mode,
    input  logic [SH_W-1:0] sh,
    input  logic            rc_en,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            out_valid,
    output logic [XLEN-1:0] sum_o,
    output logic [2:0]      cond_o
);
    logic [XLEN-1:0] b_ext;
    logic [XLEN-1:0] b_shl;
    logic [XLEN-1:0] sum_next;
    cond_t           cond_next;

    sadd_bext #(.XLEN(XLEN)) u_bext (
        .mode  (mode),
        .b_in  (opb),
        .b_out (b_ext)
    );

    sadd_shl #(.XLEN(XLEN), .SH_W(SH_W)) u_shl (
        .sh      (sh),
        .val     (b_ext),
        .shifted (b_shl)
    );

    // Modulo add; the carry is not kept.
    assign sum_next = b_shl + opa;

    sadd_cond #(.XLEN(XLEN)) u_cond (
        .val  (sum_next),
        .cond (cond_next)
    );

    // Output valid tracks the input valid by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture the sum for accepted requests only.
    always_ff @(posedge clk) begin
        if (!rst_n)        sum_o <= '0;
        else if (in_valid) sum_o <= sum_next;
    end

    // Refresh the condition field only when requested.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cond_o <= '0;
        else if (in_valid && rc_en) cond_o <= cond_next;
    end
endmodule

// File: rtl/sadd_chk.sv
// Checker for shadd_agu: temporal properties on its ports, bound below.
module sadd_chk #(
    parameter int XLEN = 64,
    parameter int SH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [1:0]      mode,
    input logic [SH_W-1:0] sh,
    input logic            rc_en,
    input logic [XLEN-1:0] opa,
    input logic [XLEN-1:0] opb,
    input logic            out_valid,
    input logic [XLEN-1:0] sum_o,
    input logic [2:0]      cond_o
);
    // R7
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(sum_o));

    // R9
    cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && rc_en) |=> $stable(cond_o));

    // R9
    cond_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cond_o));

    // R9
    cond_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rc_en) |=> (cond_o == {sum_o[XLEN-1],
                                             !sum_o[XLEN-1] && (sum_o != '0),
                                             sum_o == '0}));

    // R1
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opa == '0) |=> (sum_o[0] == 1'b0));
endmodule

bind shadd_agu sadd_chk #(.XLEN(XLEN), .SH_W(SH_W)) u_chk (.*);

// File: tb/sim_shadd_agu.sv
// Bench for shadd_agu: directed corners plus seeded random requests.
module sim_shadd_agu;
    localparam int XLEN = 64;
    localparam int SH_W = 2;
    localparam int HALF = XLEN / 2;
    localparam time TCLK = 10ns;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [1:0]      mode = '0;
    logic [SH_W-1:0] sh = '0;
    logic            rc_en = 1'b0;
    logic [XLEN-1:0] opa = '0;
    logic [XLEN-1:0] opb = '0;
    logic            out_valid;
    logic [XLEN-1:0] sum_o;
    logic [2:0]      cond_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [XLEN-1:0] exp_sum = '0;
    logic [2:0]      exp_cond = '0;

    shadd_agu #(.XLEN(XLEN), .SH_W(SH_W)) u0 (.*);

    always #(TCLK / 2) clk = ~clk;

    // Reference model of R1-style behaviour, written from the requirements.
    function automatic logic [XLEN-1:0] model_sum(input logic [1:0] m, input logic [SH_W-1:0] s,
                                                  input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
        logic [XLEN-1:0] bb;
        int amt;
        bb = b;
        if (m == 2'b01) for (int i = HALF; i < XLEN; i++) bb[i] = b[HALF-1];
        if (m == 2'b10) for (int i = HALF; i < XLEN; i++) bb[i] = 1'b0;
        amt = int'(s) + 1;
        return (bb << amt) + a;
    endfunction

    function automatic logic [2:0] model_cond(input logic [XLEN-1:0] v);
        if (v == '0) return 3'b001;
        if (v[XLEN-1]) return 3'b100;
        return 3'b010;
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request at the falling edge, check after the next rising edge.
    task automatic op(input string req, input logic v, input logic [1:0] m, input logic [SH_W-1:0] s,
                      input logic rc, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
        @(negedge clk);
        in_valid = v; mode = m; sh = s; rc_en = rc; opa = a; opb = b;
        if (v) exp_sum = model_sum(m, s, a, b);
        if (v && rc) exp_cond = model_cond(exp_sum);
        @(posedge clk);
        #1;
        check({req, " sum"}, sum_o, exp_sum);
        check({req, " cond"}, {61'd0, cond_o}, {61'd0, exp_cond});
        check({req, " valid"}, {63'd0, out_valid}, {63'd0, v});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check("R10 valid", {63'd0, out_valid}, 64'd0);
        check("R10 sum", sum_o, 64'd0);
        check("R10 cond", {61'd0, cond_o}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 sh=0 shifts by one, sh=3 by four
        op("R1 sh0", 1, 2'b00, 2'd0, 1, 64'd0, 64'd1);
        check("R1 sh0 value", sum_o, 64'd2);
        op("R1 sh3", 1, 2'b00, 2'd3, 1, 64'd0, 64'd1);
        check("R1 sh3 value", sum_o, 64'd16);
        // R2 top bits dropped, low bits zero
        op("R2 drop", 1, 2'b00, 2'd0, 1, 64'd0, 64'hC000_0000_0000_0001);
        check("R2 drop value", sum_o, 64'h8000_0000_0000_0002);
        // R3 wrap: carry discarded, sum zero
        op("R3 wrap", 1, 2'b00, 2'd0, 1, 64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000);
        check("R3 wrap value", sum_o, 64'd0);
        // R4 mode codes on the same B
        op("R4 full", 1, 2'b00, 2'd1, 1, 64'd5, 64'h1234_0000_8000_0003);
        op("R4 rsvd", 1, 2'b11, 2'd1, 1, 64'd5, 64'h1234_0000_8000_0003);
        // R5 signed word extends bit HALF-1
        op("R5 sword", 1, 2'b01, 2'd0, 1, 64'd0, 64'h1234_0000_8000_0000);
        check("R5 sword value", sum_o, 64'hFFFF_FFFF_0000_0000);
        op("R5 sword pos", 1, 2'b01, 2'd2, 1, 64'd1, 64'hFFFF_FFFF_0000_0001);
        check("R5 sword pos value", sum_o, 64'd9);
        // R6 unsigned word clears upper half
        op("R6 uword", 1, 2'b10, 2'd0, 1, 64'd0, 64'hFFFF_FFFF_8000_0000);
        check("R6 uword value", sum_o, 64'h0000_0001_0000_0000);
        // R8 hold while idle; R9 no refresh without rc_en
        op("R8 idle", 0, 2'b00, 2'd3, 1, 64'd77, 64'd99);
        op("R9 norc", 1, 2'b00, 2'd0, 0, 64'h8000_0000_0000_0000, 64'd0);
        op("R9 neg", 1, 2'b00, 2'd0, 1, 64'h8000_0000_0000_0000, 64'd0);
        op("R9 pos", 1, 2'b00, 2'd0, 1, 64'd3, 64'd0);

        // R7 random mix of requests and gaps
        for (int n = 0; n < 400; n++) begin
            op("R7 rand", 1'($urandom % 4 != 0), 2'($urandom), SH_W'($urandom), 1'($urandom),
               {$urandom, $urandom}, {$urandom, $urandom});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule